// File: doc/BRIEF.md
# Two-Wire Full-Bridge Command Decoder

This block turns a pair of direction inputs into the four gate enables of a full bridge (one high-side and one low-side switch on each of two half-bridges). The input pair selects forward drive, reverse drive, braking with both low-side switches on, or coast with every switch off. While a drive direction is held, the current regulator can raise a chop request. This moves the bridge into its decay phases: fast decay reverses the bridge, and slow decay shorts the winding through the low-side switches. The direction inputs pick only the polarity.

No switch moves straight from its high-side to its low-side state or back. Every such flip passes through a parameterised dead interval with both enables low. When both inputs stay low for a parameterised number of cycles, the block goes into low-power standby. The first non-idle input wakes it. It then raises a one-cycle exit pulse, which other blocks use to clear latched overcurrent faults, and holds all outputs off for a wake-up interval. A fault-disable input turns every switch off. All intervals are counted in system clock cycles, and all enables are registered.

Top module: `hbridge_cmd_decoder`

## Requirements
- R1: With standby clear, no hold-off running and no fault, the pair in_a=1, in_b=0 without chop gives hs_en=2'b01 and ls_en=2'b10. Bit 0 is half-bridge A and bit 1 is half-bridge B. The enables follow the inputs sampled at the previous clock edge.
- R2: With the same conditions, in_a=0, in_b=1 without chop gives hs_en=2'b10 and ls_en=2'b01.
- R3: in_a=1, in_b=1 gives hs_en=2'b00 and ls_en=2'b11 (brake), whether or not chop is requested.
- R4: in_a=0, in_b=0 turns every enable off, so hiz is 2'b11. The hiz bit of a half-bridge is high exactly when both of its enables are low.
- R5: A chop request during forward drive turns on the low side of half-bridge A. Half-bridge B then takes its high side when decay_fast=1 and its low side when decay_fast=0. During reverse drive the same holds with the two half-bridges swapped.
- R6: When a half-bridge's target moves directly between high side and low side, both of its enables stay low for DEAD_CYCLES clock cycles before the new side turns on.
- R7: The high-side and low-side enables of one half-bridge are never high together.
- R8: fault_kill=1 forces all four enables low one cycle later, whatever the other inputs are.
- R9: standby rises after STANDBY_CYCLES consecutive sampled cycles with both inputs low. A high on either input restarts the count.
- R10: While standby is high, and for WAKE_CYCLES cycles after the edge that clears it, every enable is low. The edge that clears it is the first one at which either input is sampled high.
- R11: standby_exit is high for exactly one cycle, right after standby falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_a | input | 1 | Direction input A |
| in_b | input | 1 | Direction input B |
| chop_req | input | 1 | Decay request from the current regulator |
| decay_fast | input | 1 | Decay phase: 1 fast, 0 slow |
| fault_kill | input | 1 | Global disable of all switches |
| hs_en | output | 2 | High-side enables, bit 0 half-bridge A |
| ls_en | output | 2 | Low-side enables, bit 0 half-bridge A |
| hiz | output | 2 | Half-bridge floating flags |
| standby | output | 1 | Low-power standby active |
| standby_exit | output | 1 | One-cycle pulse on leaving standby |

## Verification
Each enable follows the inputs one clock edge after they are sampled. The exception is a direct side flip, where the new side comes DEAD_CYCLES edges later than it otherwise would. standby rises on the STANDBY_CYCLES-th edge of an idle run. standby_exit and the fall of standby come on the first edge that sees an input high. Drive comes back WAKE_CYCLES+1 edges after that. The bench steps a behavioural model at every rising edge on the same sampled inputs and compares all outputs a quarter period later. Inputs change only on falling edges. Directed checks sample at the exact edge counts above, on both sides of each boundary.

// File: rtl/hbridge_cmd_decoder.sv
module hbridge_cmd_decoder #(
  parameter int STANDBY_CYCLES = 50000,
  parameter int WAKE_CYCLES    = 1500,
  parameter int DEAD_CYCLES    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_a,
  input  logic       in_b,
  input  logic       chop_req,
  input  logic       decay_fast,
  input  logic       fault_kill,
  output logic [1:0] hs_en,
  output logic [1:0] ls_en,
  output logic [1:0] hiz,
  output logic       standby,
  output logic       standby_exit
);

  localparam int IDLE_W = $clog2(STANDBY_CYCLES + 1);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);
  localparam int DEAD_W = $clog2(DEAD_CYCLES + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(STANDBY_CYCLES - 1);
  localparam logic [WAKE_W-1:0] WAKE_LOAD = WAKE_W'(WAKE_CYCLES);
  localparam logic [DEAD_W-1:0] DEAD_LOAD = DEAD_W'(DEAD_CYCLES - 1);

  logic              sleep_q, exit_q;
  logic [IDLE_W-1:0] idle_cnt;
  logic [WAKE_W-1:0] wake_cnt;
  logic              drive_ok, any_in;
  logic [1:0]        want_hi, want_lo;
  logic [1:0]        hs_q, ls_q;

  assign any_in   = in_a | in_b;
  assign drive_ok = !sleep_q && (wake_cnt == '0) && !fault_kill;

  always_comb begin
    want_hi = 2'b00;
    want_lo = 2'b00;
    if (drive_ok) begin
      unique case ({in_a, in_b})
        2'b10: if (chop_req) begin
                 want_lo[0] = 1'b1;
                 want_hi[1] = decay_fast;
                 want_lo[1] = !decay_fast;
               end else begin
                 want_hi[0] = 1'b1;
                 want_lo[1] = 1'b1;
               end
        2'b01: if (chop_req) begin
                 want_lo[1] = 1'b1;
                 want_hi[0] = decay_fast;
                 want_lo[0] = !decay_fast;
               end else begin
                 want_hi[1] = 1'b1;
                 want_lo[0] = 1'b1;
               end
        2'b11: want_lo = 2'b11;
        default: ;
      endcase
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [DEAD_W-1:0] dead_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hs_q[h]  <= 1'b0;
        ls_q[h]  <= 1'b0;
        dead_cnt <= '0;
      end else if (dead_cnt != '0) begin
        dead_cnt <= dead_cnt - 1'b1;
      end else if ((hs_q[h] && want_lo[h]) || (ls_q[h] && want_hi[h])) begin
        hs_q[h]  <= 1'b0;
        ls_q[h]  <= 1'b0;
        dead_cnt <= DEAD_LOAD;
      end else begin
        hs_q[h] <= want_hi[h];
        ls_q[h] <= want_lo[h];
      end
    end

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en[h] && ls_en[h]));
    p_dead_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hs_en[h] |=> !ls_en[h]);
    p_dead_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ls_en[h] |=> !hs_en[h]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q  <= 1'b0;
      exit_q   <= 1'b0;
      idle_cnt <= '0;
      wake_cnt <= '0;
    end else begin
      exit_q <= 1'b0;
      if (sleep_q) begin
        if (any_in) begin
          sleep_q  <= 1'b0;
          exit_q   <= 1'b1;
          wake_cnt <= WAKE_LOAD;
          idle_cnt <= '0;
        end
      end else begin
        if (wake_cnt != '0) wake_cnt <= wake_cnt - 1'b1;
        if (any_in) idle_cnt <= '0;
        else if (idle_cnt == IDLE_LAST) begin
          sleep_q  <= 1'b1;
          idle_cnt <= '0;
        end else idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  assign hs_en        = hs_q;
  assign ls_en        = ls_q;
  assign hiz          = ~(hs_q | ls_q);
  assign standby      = sleep_q;
  assign standby_exit = exit_q;

  p_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_kill |=> (hs_en == 2'b00 && ls_en == 2'b00));
  p_coast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_a && !in_b) |=> (hiz == 2'b11));
  p_sleep_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (hs_en == 2'b00 && ls_en == 2'b00));
  p_exit_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    standby_exit |-> (!standby && $past(standby)));
  p_exit_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    standby_exit |=> !standby_exit);

endmodule

// File: tb/hbridge_cmd_decoder_tb.sv
module hbridge_cmd_decoder_tb;
  localparam int STBY = 20;
  localparam int WAKE = 5;
  localparam int DEAD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_a = 0, in_b = 0, chop_req = 0, decay_fast = 0, fault_kill = 0;
  logic [1:0] hs_en, ls_en, hiz;
  logic standby, standby_exit;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R4";

  int m_hs[2], m_ls[2], m_dc[2];
  int m_sleep, m_wake, m_idle, m_exit;

  always #10 clk = ~clk;

  hbridge_cmd_decoder #(.STANDBY_CYCLES(STBY), .WAKE_CYCLES(WAKE), .DEAD_CYCLES(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .chop_req(chop_req),
    .decay_fast(decay_fast), .fault_kill(fault_kill), .hs_en(hs_en), .ls_en(ls_en),
    .hiz(hiz), .standby(standby), .standby_exit(standby_exit));

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int wh[2], wl[2];
    int ok, nx_exit;
    if (!rst_n) begin
      for (int h = 0; h < 2; h++) begin m_hs[h] = 0; m_ls[h] = 0; m_dc[h] = 0; end
      m_sleep = 0; m_wake = 0; m_idle = 0; m_exit = 0;
    end else begin
      wh = '{0, 0}; wl = '{0, 0};
      ok = (m_sleep == 0 && m_wake == 0 && !fault_kill);
      if (ok) begin
        if (in_a && !in_b) begin
          if (chop_req) begin wl[0] = 1; wh[1] = decay_fast; wl[1] = !decay_fast; end
          else begin wh[0] = 1; wl[1] = 1; end
        end else if (!in_a && in_b) begin
          if (chop_req) begin wl[1] = 1; wh[0] = decay_fast; wl[0] = !decay_fast; end
          else begin wh[1] = 1; wl[0] = 1; end
        end else if (in_a && in_b) begin
          wl[0] = 1; wl[1] = 1;
        end
      end
      for (int h = 0; h < 2; h++) begin
        if (m_dc[h] > 0) m_dc[h]--;
        else if ((m_hs[h] && wl[h]) || (m_ls[h] && wh[h])) begin
          m_hs[h] = 0; m_ls[h] = 0; m_dc[h] = DEAD - 1;
        end else begin m_hs[h] = wh[h]; m_ls[h] = wl[h]; end
      end
      nx_exit = 0;
      if (m_sleep) begin
        if (in_a || in_b) begin m_sleep = 0; m_wake = WAKE; nx_exit = 1; m_idle = 0; end
      end else begin
        if (m_wake > 0) m_wake--;
        if (in_a || in_b) m_idle = 0;
        else if (m_idle == STBY - 1) begin m_sleep = 1; m_idle = 0; end
        else m_idle++;
      end
      m_exit = nx_exit;
    end
    #5;
    if (!done) begin
      check(cur_req, "hs_en", hs_en, m_hs[1] * 2 + m_hs[0]);
      check(cur_req, "ls_en", ls_en, m_ls[1] * 2 + m_ls[0]);
      check(cur_req, "hiz", hiz, (!(m_hs[1] || m_ls[1])) * 2 + (!(m_hs[0] || m_ls[0])));
      check(cur_req, "standby", standby, m_sleep);
      check(cur_req, "standby_exit", standby_exit, m_exit);
      check("R7", "overlap", int'(|(hs_en & ls_en)), 0);
    end
  end

  task automatic drive(logic a, logic b, logic c, logic f, logic k);
    @(negedge clk);
    in_a = a; in_b = b; chop_req = c; decay_fast = f; fault_kill = k;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R4", "reset hiz", hiz, 3);
    check("R9", "reset standby", standby, 0);
    rst_n = 1;

    cur_req = "R1"; drive(1, 0, 0, 0, 0); run(4);
    check("R1", "fwd hs", hs_en, 2'b01); check("R1", "fwd ls", ls_en, 2'b10);

    cur_req = "R6"; drive(0, 1, 0, 0, 0); @(posedge clk); #5;
    check("R6", "dead hs", hs_en, 0); check("R6", "dead ls", ls_en, 0);
    cur_req = "R2"; run(5);
    check("R2", "rev hs", hs_en, 2'b10); check("R2", "rev ls", ls_en, 2'b01);

    cur_req = "R3"; drive(1, 1, 1, 1, 0); run(5);
    check("R3", "brake hs", hs_en, 0); check("R3", "brake ls", ls_en, 2'b11);

    cur_req = "R5"; drive(1, 0, 0, 0, 0); run(5);
    drive(1, 0, 1, 1, 0); run(5);
    check("R5", "fwd fast hs", hs_en, 2'b10); check("R5", "fwd fast ls", ls_en, 2'b01);
    drive(1, 0, 1, 0, 0); run(5);
    check("R5", "fwd slow ls", ls_en, 2'b11);
    drive(0, 1, 1, 1, 0); run(6);
    check("R5", "rev fast hs", hs_en, 2'b01); check("R5", "rev fast ls", ls_en, 2'b10);

    cur_req = "R8"; drive(1, 0, 0, 0, 1); @(posedge clk); #5;
    check("R8", "fault hs", hs_en, 0); check("R8", "fault ls", ls_en, 0);
    drive(1, 0, 0, 0, 0); run(3);

    cur_req = "R9"; drive(0, 0, 0, 0, 0); run(10);
    check("R4", "coast hiz", hiz, 3);
    drive(1, 0, 0, 0, 0); drive(0, 0, 0, 0, 0);
    repeat (STBY - 1) @(posedge clk); #5;
    check("R9", "not yet", standby, 0);
    @(posedge clk); #5;
    check("R9", "entered", standby, 1);
    run(4);

    cur_req = "R10"; drive(1, 0, 0, 0, 0); @(posedge clk); #5;
    check("R11", "exit pulse", standby_exit, 1);
    check("R10", "left standby", standby, 0);
    @(posedge clk); #5;
    check("R11", "pulse ends", standby_exit, 0);
    repeat (WAKE - 1) @(posedge clk); #5;
    check("R10", "held", hs_en, 0);
    @(posedge clk); #5;
    check("R10", "drive back", hs_en, 2'b01);

    cur_req = "R6";
    for (int i = 0; i < 600; i++) begin
      int r = $urandom;
      int len = (r[11:10] == 0) ? STBY + 6 : 1 + (r >> 12) % 4;
      drive(r[0], r[1] & ~r[5], r[2], r[3], (r[9:6] == 0));
      run(len - 1);
    end

    drive(0, 0, 0, 0, 0); run(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule